// File: doc/BRIEF.md
# Dual-Mode Multiplexed Bus Register Port

This block connects an external processor with an 8-bit multiplexed address/data bus to a small internal register bank. A static mode input selects the strobe convention. With mode low, the port uses separate active-low read and write strobes. With mode high, the read pin becomes a shared active-low data strobe and the write pin becomes a read/write select, high for read and low for write. An address-latch strobe carries the register address on the shared bus. A chip select that is active low qualifies every access.

All bus pins, data included, pass through a two-stage synchronizer into the system clock domain. A state machine then decodes accesses from the synchronized pins. Its states are `ST_IDLE`, `ST_READ`, `ST_WRITE` and `ST_RECOVER`, joined by these transitions:

- **idle_to_read**: a read condition is seen.
- **idle_to_write**: a write condition is seen. This takes priority over idle_to_read.
- **read_to_idle**: the read condition ends.
- **write_to_recover**: any qualifying strobe rises. This transition emits the write pulse.
- **recover_to_idle**: every strobe is released, or chip select goes high.

During a read the port enables its bus output and returns the register at the latched address. When a write ends, it issues one single-cycle write pulse that carries the latched address and the captured data. The demonstration bank holds four registers at addresses 0x10 to 0x13.

Top module: `mux_bus_port`

## Requirements
- R1: After reset, `ad_oe_o` and `wr_stb_o` are 0, and every register in the bank reads 0x00.
- R2: The address is taken from `ad_i` at the falling edge of `ale_i`. Later changes on `ad_i` while `ale_i` stays low do not change which register is read or written.
- R3: While `cs_n_i` is high, no strobe pattern enables the bus output or produces a write pulse.
- R4: In mode 0, `ad_oe_o` is 1 and `ad_o` carries the addressed register while `rd_n_i` and `cs_n_i` are both low.
- R5: In mode 0, a write with `wr_n_i` and `cs_n_i` both low commits when either of them rises. It yields exactly one write pulse carrying the latched address and the bus data.
- R6: In mode 1, `ad_oe_o` is 1 and `ad_o` carries the addressed register while `rd_n_i` (data strobe) and `cs_n_i` are low and `wr_n_i` is high.
- R7: In mode 1, a write with `rd_n_i`, `cs_n_i` and `wr_n_i` all low commits when the first of the three rises, with exactly one pulse. If `wr_n_i` rises first, the bus stays undriven until the strobes are released.
- R8: An address outside 0x10 to 0x13 reads as 0x00, and a write to it leaves every register unchanged.
- R9: `ad_oe_o` changes at the third rising clock edge after the pin change that starts or ends a read. It is therefore cleared within one clock of the synchronized read condition ending.
- R10: `wr_stb_o` is high for exactly one clock per bus write. It rises at the third rising edge after the strobe that ends the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Strobe convention: 0 = separate read and write strobes, 1 = data strobe plus read/write select |
| ale_i | input | 1 | Address latch strobe; the address is taken at its falling edge |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read strobe (mode 0) or data strobe (mode 1), active low |
| wr_n_i | input | 1 | Write strobe (mode 0) or read/write select (mode 1) |
| ad_i | input | 8 | Multiplexed address/data bus, input side |
| ad_o | output | 8 | Read data driven toward the bus |
| ad_oe_o | output | 1 | Bus output enable |
| wr_stb_o | output | 1 | Single-cycle internal write pulse |
| wr_addr_o | output | 8 | Address carried by the write pulse |
| wr_data_o | output | 8 | Data carried by the write pulse |

## Verification
Every pin change needs three rising clock edges to reach an output: two for the synchronizer and one for the state register. The bench drives all inputs on falling clock edges. It checks `ad_oe_o` and `ad_o` exactly three falling edges after a read starts or ends, and it also confirms that the output enable is still low one edge earlier. A monitor samples the write pulse on falling edges. Its count and payload are checked four falling edges after the ending strobe, and checked again several cycles later to show that no second pulse followed.

// File: rtl/mbp_pkg.sv
package mbp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_RECOVER
    } port_state_t;

    localparam logic MODE_SPLIT  = 1'b0;
    localparam logic MODE_STROBE = 1'b1;

endpackage

// File: rtl/mbp_sync.sv
module mbp_sync #(
    parameter int W      = 12,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/mbp_ctrl.sv
module mbp_ctrl
    import mbp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_i,
    input  logic         s_ale,
    input  logic         s_cs_n,
    input  logic         s_rd_n,
    input  logic         s_wr_n,
    input  logic [W-1:0] s_ad,
    output logic [W-1:0] addr_q,
    output logic         oe_o,
    output logic         wr_stb_o,
    output logic [W-1:0] wr_addr_o,
    output logic [W-1:0] wr_data_o
);

    port_state_t  st_q, st_d;
    logic         ale_d;
    logic         rd_cond, wr_cond, quiet;
    logic [W-1:0] wdata_q;

    // access decode from synchronized pins
    always_comb begin
        if (mode_i == MODE_STROBE) begin
            rd_cond = !s_cs_n && !s_rd_n && s_wr_n;
            wr_cond = !s_cs_n && !s_rd_n && !s_wr_n;
            quiet   = s_cs_n || s_rd_n;
        end else begin
            rd_cond = !s_cs_n && !s_rd_n;
            wr_cond = !s_cs_n && !s_wr_n;
            quiet   = s_cs_n || (s_rd_n && s_wr_n);
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (wr_cond)      st_d = ST_WRITE;
                else if (rd_cond) st_d = ST_READ;
            end
            ST_READ: begin
                if (!rd_cond)     st_d = ST_IDLE;
            end
            ST_WRITE: begin
                if (!wr_cond)     st_d = ST_RECOVER;
            end
            ST_RECOVER: begin
                if (quiet)        st_d = ST_IDLE;
            end
            default:              st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // address latch on falling edge of the synchronized address strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ale_d  <= 1'b0;
            addr_q <= '0;
        end else begin
            ale_d <= s_ale;
            if (ale_d && !s_ale) addr_q <= s_ad;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdata_q   <= '0;
            wr_stb_o  <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
        end else begin
            if (st_d == ST_WRITE) wdata_q <= s_ad;
            wr_stb_o <= (st_q == ST_WRITE) && (st_d == ST_RECOVER);
            if ((st_q == ST_WRITE) && (st_d == ST_RECOVER)) begin
                wr_addr_o <= addr_q;
                wr_data_o <= wdata_q;
            end
        end
    end

    assign oe_o = (st_q == ST_READ);

endmodule

// File: rtl/mbp_regbank.sv
module mbp_regbank #(
    parameter int W         = 8,
    parameter int NUM_REGS  = 4,
    parameter int BASE_ADDR = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_stb_i,
    input  logic [W-1:0] wr_addr_i,
    input  logic [W-1:0] wr_data_i,
    input  logic [W-1:0] rd_addr_i,
    output logic [W-1:0] rd_data_o
);

    logic [W-1:0] regs [NUM_REGS];

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            localparam logic [W-1:0] MY_ADDR = W'(BASE_ADDR + g);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    regs[g] <= '0;
                else if (wr_stb_i && (wr_addr_i == MY_ADDR))
                    regs[g] <= wr_data_i;
            end
        end
    endgenerate

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr_i == W'(BASE_ADDR + i)) rd_data_o = regs[i];
        end
    end

endmodule

// File: rtl/mux_bus_port.sv
module mux_bus_port #(
    parameter int W         = 8,
    parameter int SYNC_LEN  = 2,
    parameter int NUM_REGS  = 4,
    parameter int BASE_ADDR = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_i,
    input  logic         ale_i,
    input  logic         cs_n_i,
    input  logic         rd_n_i,
    input  logic         wr_n_i,
    input  logic [W-1:0] ad_i,
    output logic [W-1:0] ad_o,
    output logic         ad_oe_o,
    output logic         wr_stb_o,
    output logic [W-1:0] wr_addr_o,
    output logic [W-1:0] wr_data_o
);

    localparam int SW = W + 4;
    localparam logic [SW-1:0] PIN_IDLE = {1'b0, 1'b1, 1'b1, 1'b1, {W{1'b0}}};

    logic [SW-1:0] pins_s;
    logic          s_ale, s_cs_n, s_rd_n, s_wr_n;
    logic [W-1:0]  s_ad;
    logic [W-1:0]  addr_q;
    logic [W-1:0]  rdata;

    mbp_sync #(.W(SW), .STAGES(SYNC_LEN), .RST_VAL(PIN_IDLE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({ale_i, cs_n_i, rd_n_i, wr_n_i, ad_i}),
        .q_o   (pins_s)
    );

    assign {s_ale, s_cs_n, s_rd_n, s_wr_n, s_ad} = pins_s;

    mbp_ctrl #(.W(W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_i),
        .s_ale     (s_ale),
        .s_cs_n    (s_cs_n),
        .s_rd_n    (s_rd_n),
        .s_wr_n    (s_wr_n),
        .s_ad      (s_ad),
        .addr_q    (addr_q),
        .oe_o      (ad_oe_o),
        .wr_stb_o  (wr_stb_o),
        .wr_addr_o (wr_addr_o),
        .wr_data_o (wr_data_o)
    );

    mbp_regbank #(.W(W), .NUM_REGS(NUM_REGS), .BASE_ADDR(BASE_ADDR)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb_i  (wr_stb_o),
        .wr_addr_i (wr_addr_o),
        .wr_data_i (wr_data_o),
        .rd_addr_i (addr_q),
        .rd_data_o (rdata)
    );

    assign ad_o = ad_oe_o ? rdata : '0;

endmodule

// File: rtl/mbp_checker.sv
module mbp_checker #(
    parameter int W         = 8,
    parameter int NUM_REGS  = 4,
    parameter int BASE_ADDR = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         mode,
    input logic         s_cs_n,
    input logic         s_rd_n,
    input logic         s_wr_n,
    input logic [W-1:0] addr_q,
    input logic [W-1:0] ad_o,
    input logic         oe,
    input logic         wr_stb
);

    logic rd_ok;
    logic undef;

    assign rd_ok = !s_cs_n && !s_rd_n && (mode ? s_wr_n : 1'b1);
    assign undef = (int'(addr_q) < BASE_ADDR) || (int'(addr_q) >= BASE_ADDR + NUM_REGS);

    assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    assert_cs_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_cs_n |=> !oe);

    assert_oe_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && !rd_ok) |=> !oe);

    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !oe);

    assert_undef_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && undef) |-> (ad_o == '0));

    assert_oe_needs_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> $past(rd_ok));

endmodule

bind mux_bus_port mbp_checker #(.W(W), .NUM_REGS(NUM_REGS), .BASE_ADDR(BASE_ADDR)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode_i),
    .s_cs_n (s_cs_n),
    .s_rd_n (s_rd_n),
    .s_wr_n (s_wr_n),
    .addr_q (addr_q),
    .ad_o   (ad_o),
    .oe     (ad_oe_o),
    .wr_stb (wr_stb_o)
);

// File: tb/mux_bus_port_tb.sv
module mux_bus_port_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mode_i;
    logic       ale_i, cs_n_i, rd_n_i, wr_n_i;
    logic [7:0] ad_i;
    logic [7:0] ad_o;
    logic       ad_oe_o;
    logic       wr_stb_o;
    logic [7:0] wr_addr_o, wr_data_o;

    int         vectors = 0;
    int         miscompares = 0;
    int         pulses = 0;
    logic [7:0] last_a, last_d;
    logic [7:0] model [256];
    bit         done = 0;

    always #5 clk = ~clk;

    mux_bus_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_i),
        .ale_i     (ale_i),
        .cs_n_i    (cs_n_i),
        .rd_n_i    (rd_n_i),
        .wr_n_i    (wr_n_i),
        .ad_i      (ad_i),
        .ad_o      (ad_o),
        .ad_oe_o   (ad_oe_o),
        .wr_stb_o  (wr_stb_o),
        .wr_addr_o (wr_addr_o),
        .wr_data_o (wr_data_o)
    );

    // pulse monitor, samples away from the active edge
    always @(negedge clk) begin
        if (wr_stb_o) begin
            pulses = pulses + 1;
            last_a = wr_addr_o;
            last_d = wr_data_o;
        end
    end

    function automatic bit is_def(input logic [7:0] a);
        return (a >= 8'h10) && (a < 8'h14);
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        return is_def(a) ? model[a] : 8'h00;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_pins();
        ale_i  = 1'b0;
        cs_n_i = 1'b1;
        rd_n_i = 1'b1;
        wr_n_i = 1'b1;
    endtask

    task automatic do_reset(input logic m);
        @(negedge clk);
        rst_n  = 1'b0;
        mode_i = m;
        idle_pins();
        ad_i = 8'h00;
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // R2: junk on the bus after the address strobe falls
    task automatic set_addr(input logic [7:0] a);
        @(negedge clk);
        ale_i = 1'b1;
        ad_i  = a;
        repeat (3) @(negedge clk);
        ale_i = 1'b0;
        repeat (3) @(negedge clk);
        ad_i = 8'($urandom);
    endtask

    task automatic do_read(input logic [7:0] a, input string req, input bit end_cs);
        set_addr(a);
        cs_n_i = 1'b0;
        if (mode_i) wr_n_i = 1'b1;
        rd_n_i = 1'b0;
        repeat (2) @(negedge clk);
        check({req, " R9 oe not yet"}, {7'd0, ad_oe_o}, 8'h00);
        @(negedge clk);
        check({req, " oe"}, {7'd0, ad_oe_o}, 8'h01);
        check({req, " data R2"}, ad_o, exp_rd(a));
        if (end_cs) cs_n_i = 1'b1;
        else        rd_n_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 oe released", {7'd0, ad_oe_o}, 8'h00);
        idle_pins();
        repeat (2) @(negedge clk);
    endtask

    // end_sel: mode 0 -> 0 write strobe, 1 chip select
    //          mode 1 -> 0 data strobe, 1 chip select, 2 read/write select
    task automatic do_write(input logic [7:0] a, input logic [7:0] d, input int end_sel);
        int p0;
        string req;
        req = mode_i ? "R7" : "R5";
        set_addr(a);
        ad_i = d;
        p0 = pulses;
        cs_n_i = 1'b0;
        wr_n_i = 1'b0;
        if (mode_i) rd_n_i = 1'b0;
        repeat (4) @(negedge clk);
        check({req, " no pulse while strobe held"}, 8'(pulses - p0), 8'd0);
        if (end_sel == 1)      cs_n_i = 1'b1;
        else if (end_sel == 2) wr_n_i = 1'b1;
        else if (mode_i)       rd_n_i = 1'b1;
        else                   wr_n_i = 1'b1;
        repeat (4) @(negedge clk);
        check({req, " R10 one pulse"}, 8'(pulses - p0), 8'd1);
        check({req, " pulse addr"}, last_a, a);
        check({req, " pulse data"}, last_d, d);
        check({req, " no drive after write"}, {7'd0, ad_oe_o}, 8'h00);
        ad_i = 8'($urandom);
        repeat (2) @(negedge clk);
        idle_pins();
        repeat (4) @(negedge clk);
        check("R10 no second pulse", 8'(pulses - p0), 8'd1);
        if (is_def(a)) model[a] = d;
    endtask

    task automatic cs_high_probe();
        int p0;
        set_addr(8'h11);
        p0 = pulses;
        cs_n_i = 1'b1;
        rd_n_i = 1'b0;
        wr_n_i = mode_i ? 1'b1 : 1'b0;
        repeat (5) @(negedge clk);
        check("R3 no drive with cs high", {7'd0, ad_oe_o}, 8'h00);
        wr_n_i = 1'b0;
        repeat (3) @(negedge clk);
        idle_pins();
        repeat (5) @(negedge clk);
        check("R3 no pulse with cs high", 8'(pulses - p0), 8'd0);
    endtask

    task automatic run_mode(input logic m);
        do_reset(m);
        check("R1 oe after reset", {7'd0, ad_oe_o}, 8'h00);
        check("R1 strobe after reset", {7'd0, wr_stb_o}, 8'h00);
        for (int r = 8'h10; r < 8'h14; r++) do_read(8'(r), "R1", 1'b0);
        do_write(8'h12, 8'hA5, 0);
        do_read(8'h12, m ? "R6" : "R4", 1'b0);
        do_write(8'h13, 8'h3C, 1);
        do_read(8'h13, m ? "R6" : "R4", 1'b1);
        if (m) begin
            do_write(8'h10, 8'h5A, 2);
            do_read(8'h10, "R7", 1'b0);
        end
        do_write(8'h40, 8'hFF, 0);
        do_read(8'h40, "R8", 1'b0);
        do_read(8'h0F, "R8", 1'b0);
        for (int r = 8'h10; r < 8'h14; r++) do_read(8'(r), "R8", 1'b0);
        cs_high_probe();
        do_read(8'h12, m ? "R6" : "R4", 1'b0);
        for (int n = 0; n < 60; n++) begin
            logic [7:0] a;
            a = ($urandom_range(0, 9) < 7) ? 8'(8'h10 + $urandom_range(0, 3)) : 8'($urandom);
            if ($urandom_range(0, 1) == 1)
                do_write(a, 8'($urandom), m ? int'($urandom_range(0, 2)) : int'($urandom_range(0, 1)));
            else
                do_read(a, m ? "R6" : "R4", 1'($urandom_range(0, 1)));
        end
    endtask

    initial begin
        void'($urandom(32'd1957));
        rst_n  = 1'b0;
        mode_i = 1'b0;
        ad_i   = 8'h00;
        idle_pins();
        run_mode(1'b0);
        run_mode(1'b1);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual hung expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule